// File: doc/BRIEF.md
# UART Interrupt Mask and Status Bank

This block gathers the event sources of a serial port into one interrupt line. A source raises an event with a one-cycle pulse on its bit of `src_evt`. If that source is enabled in the mask, the event is latched into a sticky status register. The interrupt line is high while any status bit is held. Software clears status bits by writing ones to them.

Software never loads the mask directly. A write of ones to the enable register sets mask bits, and a write of ones to the disable register clears them. Both of these registers are write-only and read as zero. A separate channel status register reads the live level of each source (`src_lvl`) whatever the mask holds. Software can therefore poll a condition that it has chosen not to take as an interrupt.

Access is through a simple register port. It takes a byte address and a one-cycle write or read strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `uirq_bank`

## Requirements
- R1: A synchronous active-low reset clears the mask, the status register, the read data and the interrupt line.
- R2: A write to byte offset 0x08 (enable) sets every mask bit whose write-data bit is 1 and leaves the mask bits written with 0 unchanged.
- R3: A write to byte offset 0x0C (disable) clears every mask bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A read of the enable or disable offset returns 0.
- R5: A write to the mask offset 0x10 or to the channel status offset 0x2C changes nothing.
- R6: A status bit (offset 0x14) is set by an event on its source only when that source's mask bit holds 1 before the clock edge of the event. A masked event leaves the status bit and the interrupt line unchanged.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it alone. If an unmasked event on the same bit arrives in the same cycle as the clearing write, the bit stays set.
- R8: A read of offset 0x2C returns `src_lvl` as sampled in the read cycle, independent of the mask and of the status register.
- R9: `irq` is high exactly when at least one status bit is set. It rises in the cycle after the edge that latches an unmasked event.
- R10: Register bit n belongs to source n. The sources are: 0 RX trigger level reached, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 overrun, 6 framing error, 7 parity error, 8 RX timeout.
- R11: Read data appears on `reg_rdata` one cycle after `reg_rd`. Unmapped offsets read 0, and so do bits at or above NUM_SRC. Write-data bits at or above NUM_SRC are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| src_evt | input | NUM_SRC | Per-source event pulses |
| src_lvl | input | NUM_SRC | Per-source live condition levels |
| irq | output | 1 | Interrupt, OR of all status bits |

## Verification
The bench builds the block with its defaults: NUM_SRC = 9, DATA_W = 32 and ADDR_W = 8. This reaches every named source bit, including the RX timeout bit at position 8, which lies above the first byte. It also leaves 23 unused data bits, which exercises the dropping of wide write data and the zero padding on reads. The 8-bit address reaches every register offset and an unmapped one. The same-cycle collision of an event with a clearing write is driven explicitly, as is a masked event.

// File: rtl/uirq_pkg.sv
// Shared register offsets, source indices and select encoding for the
// interrupt mask/status bank. Offsets are byte addresses on a word map.
package uirq_pkg;

    localparam int OFF_ENA  = 'h08;
    localparam int OFF_DIS  = 'h0C;
    localparam int OFF_MASK = 'h10;
    localparam int OFF_STAT = 'h14;
    localparam int OFF_CHAN = 'h2C;

    localparam int SRC_RX_TRIG  = 0;
    localparam int SRC_RX_EMPTY = 1;
    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 3;
    localparam int SRC_TX_FULL  = 4;
    localparam int SRC_OVERRUN  = 5;
    localparam int SRC_FRAMING  = 6;
    localparam int SRC_PARITY   = 7;
    localparam int SRC_RX_TOUT  = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENA,
        SEL_DIS,
        SEL_MASK,
        SEL_STAT,
        SEL_CHAN
    } reg_sel_e;

endpackage

// File: rtl/uirq_addr_dec.sv
// Address decoder: maps a byte address to a register select.
// Assumes word-aligned registers; address bits [1:0] are ignored.
module uirq_addr_dec
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [1:0]        unused_lsb;

    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = addr[1:0];

    // Compare the word index against each register offset.
    always_comb begin
        sel = SEL_NONE;
        if (word == WORD_W'(OFF_ENA >> 2))  sel = SEL_ENA;
        if (word == WORD_W'(OFF_DIS >> 2))  sel = SEL_DIS;
        if (word == WORD_W'(OFF_MASK >> 2)) sel = SEL_MASK;
        if (word == WORD_W'(OFF_STAT >> 2)) sel = SEL_STAT;
        if (word == WORD_W'(OFF_CHAN >> 2)) sel = SEL_CHAN;
    end

endmodule

// File: rtl/uirq_mask_bank.sv
// Mask register: set-by-one and clear-by-one vectors, one flop per source.
// Assumes set and clear come from separate write strobes; clear wins if both.
module uirq_mask_bank #(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] mask
);
    for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
        // Per-bit mask flop with clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)          mask[b] <= 1'b0;
            else if (clr_vec[b]) mask[b] <= 1'b0;
            else if (set_vec[b]) mask[b] <= 1'b1;
        end
    end

endmodule

// File: rtl/uirq_status_bank.sv
// Sticky status register: a hit sets a bit, a write-one clears it, set wins.
// Assumes hits are already gated by the mask.
module uirq_status_bank #(
    parameter int NUM_SRC = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hit_vec,
    input  logic [NUM_SRC-1:0] w1c_vec,
    output logic [NUM_SRC-1:0] status
);
    for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
        // Per-bit sticky flop with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          status[b] <= 1'b0;
            else if (hit_vec[b]) status[b] <= 1'b1;
            else if (w1c_vec[b]) status[b] <= 1'b0;
        end
    end

endmodule

// File: rtl/uirq_bank.sv
// Top: interrupt mask/status bank for a serial port.
// Decodes the register port, drives the mask and status banks, and returns
// registered read data one cycle after a read strobe. Assumes one access
// per cycle and NUM_SRC <= DATA_W.
module uirq_bank
    import uirq_pkg::*;
#(
    parameter int NUM_SRC = 9,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic               irq
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] w1c_vec;
    logic [NUM_SRC-1:0] hit_vec;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] stat_q;
    logic [DATA_W-1:0]  rd_val;
    logic [PAD_W-1:0]   unused_wdata;

    assign wbits        = reg_wdata[NUM_SRC-1:0];
    assign unused_wdata = reg_wdata[DATA_W-1:NUM_SRC];

    uirq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    // Write strobes turned into per-bit set, clear and write-one-clear vectors.
    always_comb begin
        set_vec = (reg_wr && sel == SEL_ENA)  ? wbits : '0;
        clr_vec = (reg_wr && sel == SEL_DIS)  ? wbits : '0;
        w1c_vec = (reg_wr && sel == SEL_STAT) ? wbits : '0;
        hit_vec = src_evt & mask_q;
    end

    uirq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mask    (mask_q)
    );

    uirq_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_vec (hit_vec),
        .w1c_vec (w1c_vec),
        .status  (stat_q)
    );

    // Read multiplexer; write-only and unmapped registers return zero.
    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_MASK: rd_val[NUM_SRC-1:0] = mask_q;
            SEL_STAT: rd_val[NUM_SRC-1:0] = stat_q;
            SEL_CHAN: rd_val[NUM_SRC-1:0] = src_lvl;
            default:  rd_val = '0;
        endcase
    end

    // Registered read data, zero when no read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
        else             reg_rdata <= '0;
    end

    assign irq = |stat_q;

endmodule

// File: rtl/uirq_bank_chk.sv
// Checker for uirq_bank, bound to every instance of the top module.
// Watches the register port, the sources, and the mask and status state.
module uirq_bank_chk #(
    parameter int NUM_SRC = 9,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic [NUM_SRC-1:0] src_evt,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] stat_q,
    input logic               irq
);
    logic               at_ena;
    logic               at_dis;
    logic               at_stat;
    logic               at_chan;
    logic [NUM_SRC-1:0] wb;
    logic [NUM_SRC-1:0] clr_req;

    assign at_ena  = (int'(reg_addr) >> 2) == (uirq_pkg::OFF_ENA >> 2);
    assign at_dis  = (int'(reg_addr) >> 2) == (uirq_pkg::OFF_DIS >> 2);
    assign at_stat = (int'(reg_addr) >> 2) == (uirq_pkg::OFF_STAT >> 2);
    assign at_chan = (int'(reg_addr) >> 2) == (uirq_pkg::OFF_CHAN >> 2);
    assign wb      = reg_wdata[NUM_SRC-1:0];
    assign clr_req = (reg_wr && at_stat) ? wb : '0;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && stat_q == '0 && !irq));

    // R2
    enable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && at_ena) |=> ((mask_q & $past(wb)) == $past(wb)));

    // R3
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && at_dis) |=> ((mask_q & $past(wb)) == '0));

    // R4
    wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (at_ena || at_dis)) |=> (reg_rdata == '0));

    // R6
    masked_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(src_evt & mask_q)) == '0));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_q) & ~$past(clr_req) & ~stat_q) == '0));

    // R8
    chan_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && at_chan) |=> (reg_rdata[NUM_SRC-1:0] == $past(src_lvl)));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && (src_evt & mask_q) != '0) |=> irq);

endmodule

bind uirq_bank uirq_bank_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_evt   (src_evt),
    .src_lvl   (src_lvl),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .irq       (irq)
);

// File: tb/test_uirq_bank.sv
`timescale 1ns/1ps
module test_uirq_bank;
    localparam int NUM_SRC = 9;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;

    localparam int OP_WR = 0;
    localparam int OP_RD = 1;
    localparam int OP_EV = 2;

    localparam int NV = 18;
    // op, byte address, data (write data, expected read data or event vector)
    localparam int V_OP [NV] = '{
        OP_RD, OP_RD, OP_WR, OP_RD, OP_WR, OP_RD, OP_RD, OP_WR, OP_RD,
        OP_RD, OP_EV, OP_RD, OP_WR, OP_RD, OP_WR, OP_RD, OP_WR, OP_RD};
    localparam int V_ADR [NV] = '{
        'h10, 'h14, 'h08, 'h10, 'h08, 'h10, 'h08, 'h0C, 'h10,
        'h0C, 'h00, 'h14, 'h14, 'h14, 'h10, 'h10, 'h14, 'h14};
    localparam int V_DAT [NV] = '{
        'h000, 'h000, 'h0A5, 'h0A5, 'h100, 'h1A5, 'h000, 'h021, 'h184,
        'h000, 'h1FF, 'h184, 'h004, 'h180, 'h0FF, 'h184, 'h180, 'h000};
    // Requirement checked by each read: R1 R1 - R2 - R2 R4 - R3 R4 - R6 - R7 - R5 - R7
    localparam int V_REQ [NV] = '{
        1, 1, 0, 2, 0, 2, 4, 0, 3, 4, 0, 6, 0, 7, 0, 5, 0, 7};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0;
    logic               reg_rd = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [DATA_W-1:0]  reg_wdata = '0;
    logic [DATA_W-1:0]  reg_rdata;
    logic [NUM_SRC-1:0] src_evt = '0;
    logic [NUM_SRC-1:0] src_lvl = '0;
    logic               irq;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    logic [DATA_W-1:0] rv;

    always #2.5 clk = ~clk;

    uirq_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_uirq_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_evt(src_evt), .src_lvl(src_lvl), .irq(irq)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ADDR_W'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic ev(input logic [NUM_SRC-1:0] v);
        @(negedge clk);
        src_evt = v;
        @(negedge clk);
        src_evt = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 rdata after reset", reg_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            if (V_OP[i] == OP_WR) wr(V_ADR[i], DATA_W'(V_DAT[i]));
            else if (V_OP[i] == OP_EV) ev(NUM_SRC'(V_DAT[i]));
            else begin
                rd(V_ADR[i], rv);
                check($sformatf("R%0d vector %0d", V_REQ[i], i), rv, DATA_W'(V_DAT[i]));
            end
        end
        // mask = 0x184, status = 0 here
        check("R9 irq low with empty status", 32'(irq), 0);

        // R8: live levels seen regardless of mask; reading does not disturb mask
        src_lvl = 9'h155;
        rd('h2C, rv);
        check("R8 channel status", rv, 'h155);
        wr('h2C, 'h0);
        rd('h10, rv);
        check("R5 mask after write to channel status", rv, 'h184);

        // R6: masked event (bit 0 not enabled)
        ev(9'h001);
        check("R6 irq after masked event", 32'(irq), 0);
        rd('h14, rv);
        check("R6 status after masked event", rv, 0);

        // R9/R10: parity error (bit 7) raises irq the cycle after the edge
        @(negedge clk);
        src_evt = 9'h080;
        @(negedge clk);
        src_evt = '0;
        check("R9 irq rises after unmasked event", 32'(irq), 1);
        rd('h14, rv);
        check("R10 parity source at bit 7", rv, 'h080);

        // R7: same-cycle event and clearing write, set wins
        @(negedge clk);
        src_evt = 9'h080; reg_wr = 1'b1; reg_addr = 'h14; reg_wdata = 'h080;
        @(negedge clk);
        src_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd('h14, rv);
        check("R7 set wins over clear", rv, 'h080);
        wr('h14, 'h080);
        rd('h14, rv);
        check("R7 write-one clears", rv, 0);
        check("R9 irq low after clear", 32'(irq), 0);

        // R11: unmapped read, wide write data
        rd('h30, rv);
        check("R11 unmapped read", rv, 0);
        wr('h08, 32'hFFFF_FFFF);
        rd('h10, rv);
        check("R11 upper write bits dropped", rv, 'h1FF);

        // R10: RX timeout at bit 8
        ev(9'h100);
        rd('h14, rv);
        check("R10 timeout source at bit 8", rv, 'h100);

        // R1: reset mid-run
        ev(9'h1FF);
        check("R9 irq with all sources", 32'(irq), 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after mid-run reset", 32'(irq), 0);
        rd('h10, rv);
        check("R1 mask after mid-run reset", rv, 0);
        rd('h14, rv);
        check("R1 status after mid-run reset", rv, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule